// File: doc/BRIEF.md
# Scrolling Bitmap Fetch Address and Colour Stage

This block sits between the display timing generator and video memory for the bitmap display modes. For every active pixel it turns the screen coordinate, the scroll offsets and the bitmap geometry into a byte address in a 2 MB video memory. The virtual bitmap is wider than the screen and has a power-of-two width, so a row address is a shift and the horizontal wrap is a mask. In the low-resolution mode each source pixel covers a 2x2 block of output pixels. The block issues the same address again for each repeated pixel and each repeated line, and keeps no cache.

The data returned by memory comes back into the block. It becomes a 12-bit colour in one of two ways. In direct mode the low twelve bits are used as they are. In index mode the low byte addresses a 256-entry table in the bank the controller has chosen. There are four such banks, and they are written through a simple write port. Table reads take one cycle, and direct colours are delayed by the same amount, so both formats leave the block with the same latency.

Top module: `bmp_scan_fetch`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `mem_req`, `mem_addr`, `colour` and `colour_vld` are all zero.
- R2: One cycle after `pix_de` is high, `mem_req` is 1 and `mem_addr` = (`fb_base` + ((row << L) + col) * B) mod 2^21. Here W = 2^L, row = `scroll_y` + y', col = (`scroll_x` + x') mod W, and B = 1 when `fmt_index8` = 1 or B = 2 (a 16-bit word) when `fmt_index8` = 0.
- R3: `width_sel` gives L = 9 + `width_sel`: 0 selects 512, 1 selects 1024, 2 selects 2048 and 3 selects 4096 pixels.
- R4: When `scroll_x` + x' reaches or passes W, the column wraps to (`scroll_x` + x') mod W on the same row.
- R5: The row is taken modulo H = 2^21 / (W * B), so scrolling down past the bitmap height wraps back to its top.
- R6: When `mode_half` = 0, x' = `pix_x` and y' = `pix_y`. When `mode_half` = 1, x' = `pix_x` >> 1 and y' = `pix_y` >> 1, so pixel pairs 2k and 2k+1 on line pairs 2m and 2m+1 all give the same address.
- R7: One cycle after `pix_de` is low, `mem_req` is 0 and `mem_addr` keeps its previous value.
- R8: With `fmt_index8` = 0, one cycle after `fetch_vld` the block gives `colour_vld` = 1 and `colour` = `fetch_data[11:0]`.
- R9: With `fmt_index8` = 1, one cycle after `fetch_vld` the block gives `colour_vld` = 1 and `colour` = the table entry at bank `bank_sel`, index `fetch_data[7:0]`. `fetch_data[15:8]` has no effect.
- R10: A cycle with `pal_we` = 1 stores `pal_wdata` at entry `pal_waddr`, where `pal_waddr[9:8]` is the bank and `pal_waddr[7:0]` the index. The four banks are independent.
- R11: One cycle after `fetch_vld` is low, `colour_vld` is 0 and `colour` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_x | input | 10 | Screen column of the current pixel |
| pix_y | input | 9 | Screen line of the current pixel |
| pix_de | input | 1 | Active video |
| mode_half | input | 1 | 1 = low-resolution mode, coordinates halved |
| width_sel | input | 2 | Bitmap width select (512 << value) |
| fmt_index8 | input | 1 | 1 = 8-bit table index, 0 = direct 12-bit colour |
| bank_sel | input | 2 | Colour table bank used for lookups |
| fb_base | input | 21 | Byte address of the bitmap origin |
| scroll_x | input | 12 | Horizontal scroll in pixels |
| scroll_y | input | 12 | Vertical scroll in lines |
| pal_we | input | 1 | Colour table write strobe |
| pal_waddr | input | 10 | Table write address {bank, index} |
| pal_wdata | input | 12 | Table write data |
| fetch_vld | input | 1 | Memory data valid |
| fetch_data | input | 16 | Pixel data returned by memory |
| mem_req | output | 1 | Fetch request for the address on mem_addr |
| mem_addr | output | 21 | Byte address of the pixel to fetch |
| colour | output | 12 | Output colour |
| colour_vld | output | 1 | Output colour valid |

## Verification
The assertions assume that reset is held for at least one clock edge and that `fetch_data` carries defined values whenever `fetch_vld` is high. The direct-colour property also relies on `fmt_index8` staying the same from one cycle to the next while data arrives. The stimulus changes mode, scroll and geometry settings only on falling edges. It never writes a table entry in the same cycle that entry is looked up, and it reads only table entries it has already written.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    typedef enum logic {
        FMT_DIRECT12 = 1'b0,
        FMT_INDEX8   = 1'b1
    } pix_fmt_e;

    // Base-2 log of the smallest selectable bitmap width
    localparam int unsigned WLOG_MIN = 9;

endpackage

// File: rtl/bsa_addr_gen.sv
module bsa_addr_gen
    import bsa_pkg::*;
#(
    parameter int unsigned AW  = 21,
    parameter int unsigned XW  = 10,
    parameter int unsigned YW  = 9,
    parameter int unsigned SW  = 12,
    parameter int unsigned WSW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           de,
    input  logic [XW-1:0]  px,
    input  logic [YW-1:0]  py,
    input  logic           half,
    input  logic [WSW-1:0] wsel,
    input  pix_fmt_e       fmt,
    input  logic [AW-1:0]  base,
    input  logic [SW-1:0]  sx,
    input  logic [SW-1:0]  sy,
    output logic           req_o,
    output logic [AW-1:0]  addr_o
);

    localparam int unsigned SHW = 5;

    typedef struct packed {
        logic          req;
        logic [AW-1:0] addr;
    } ag_t;

    ag_t ag_d, ag_q;

    logic [XW-1:0]  xs;
    logic [YW-1:0]  ys;
    logic [SW-1:0]  hpos, vpos;
    logic [SHW-1:0] wlog;
    logic [AW-1:0]  colmask, lin, off;

    always_comb begin
        xs      = half ? (px >> 1) : px;
        ys      = half ? (py >> 1) : py;
        hpos    = sx + SW'(xs);
        vpos    = sy + SW'(ys);
        wlog    = SHW'(WLOG_MIN) + SHW'(wsel);
        colmask = (AW'(1) << wlog) - AW'(1);
        // Truncation to AW bits after the shift wraps the row at the height
        lin     = (AW'(vpos) << wlog) | (AW'(hpos) & colmask);
        off     = (fmt == FMT_DIRECT12) ? (lin << 1) : lin;

        ag_d = ag_q;
        if (de) begin
            ag_d.req  = 1'b1;
            ag_d.addr = base + off;
        end else begin
            ag_d.req  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ag_q <= '0;
        end else begin
            ag_q <= ag_d;
        end
    end

    assign req_o  = ag_q.req;
    assign addr_o = ag_q.addr;

    p_blank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !de |=> (!req_o && $stable(addr_o)));

    p_active_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        de |=> req_o);

endmodule

// File: rtl/bsa_palette.sv
module bsa_palette #(
    parameter int unsigned CW  = 12,
    parameter int unsigned IW  = 8,
    parameter int unsigned BKW = 2
) (
    input  logic              clk,
    input  logic              we,
    input  logic [BKW+IW-1:0] waddr,
    input  logic [CW-1:0]     wdata,
    input  logic [BKW+IW-1:0] raddr,
    output logic [CW-1:0]     rdata
);

    localparam int unsigned DEPTH = 1 << (BKW + IW);

    logic [CW-1:0] mem_q [DEPTH];
    logic [CW-1:0] rd_q;

    // Read returns the value held before a same-cycle write
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        rd_q <= mem_q[raddr];
    end

    assign rdata = rd_q;

endmodule

// File: rtl/bsa_pix_out.sv
module bsa_pix_out
    import bsa_pkg::*;
#(
    parameter int unsigned CW  = 12,
    parameter int unsigned DW  = 16,
    parameter int unsigned IW  = 8,
    parameter int unsigned BKW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_vld,
    input  logic [DW-1:0]     fetch_data,
    input  pix_fmt_e          fmt,
    input  logic [BKW-1:0]    bank,
    output logic [BKW+IW-1:0] pal_raddr,
    input  logic [CW-1:0]     pal_rdata,
    output logic [CW-1:0]     colour_o,
    output logic              vld_o
);

    typedef struct packed {
        logic          vld;
        pix_fmt_e      fmt;
        logic [CW-1:0] direct;
    } po_t;

    po_t po_d, po_q;

    always_comb begin
        pal_raddr     = {bank, fetch_data[IW-1:0]};
        po_d.vld      = fetch_vld;
        po_d.fmt      = fmt;
        po_d.direct   = fetch_data[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            po_q <= '0;
        end else begin
            po_q <= po_d;
        end
    end

    always_comb begin
        if (!po_q.vld) begin
            colour_o = '0;
        end else if (po_q.fmt == FMT_INDEX8) begin
            colour_o = pal_rdata;
        end else begin
            colour_o = po_q.direct;
        end
    end

    assign vld_o = po_q.vld;

    p_direct_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && fmt == FMT_DIRECT12) |=> (vld_o && colour_o == $past(fetch_data[CW-1:0])));

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_vld |=> (!vld_o && colour_o == '0));

    p_index_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && fmt == FMT_INDEX8) |=> vld_o);

endmodule

// File: rtl/bmp_scan_fetch.sv
module bmp_scan_fetch
    import bsa_pkg::*;
#(
    parameter int unsigned AW  = 21,
    parameter int unsigned XW  = 10,
    parameter int unsigned YW  = 9,
    parameter int unsigned SW  = 12,
    parameter int unsigned WSW = 2,
    parameter int unsigned CW  = 12,
    parameter int unsigned DW  = 16,
    parameter int unsigned IW  = 8,
    parameter int unsigned BKW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XW-1:0]     pix_x,
    input  logic [YW-1:0]     pix_y,
    input  logic              pix_de,
    input  logic              mode_half,
    input  logic [WSW-1:0]    width_sel,
    input  logic              fmt_index8,
    input  logic [BKW-1:0]    bank_sel,
    input  logic [AW-1:0]     fb_base,
    input  logic [SW-1:0]     scroll_x,
    input  logic [SW-1:0]     scroll_y,
    input  logic              pal_we,
    input  logic [BKW+IW-1:0] pal_waddr,
    input  logic [CW-1:0]     pal_wdata,
    input  logic              fetch_vld,
    input  logic [DW-1:0]     fetch_data,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    output logic [CW-1:0]     colour,
    output logic              colour_vld
);

    pix_fmt_e          fmt;
    logic [BKW+IW-1:0] pal_raddr;
    logic [CW-1:0]     pal_rdata;

    assign fmt = pix_fmt_e'(fmt_index8);

    bsa_addr_gen #(
        .AW(AW), .XW(XW), .YW(YW), .SW(SW), .WSW(WSW)
    ) addr_gen_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .de     (pix_de),
        .px     (pix_x),
        .py     (pix_y),
        .half   (mode_half),
        .wsel   (width_sel),
        .fmt    (fmt),
        .base   (fb_base),
        .sx     (scroll_x),
        .sy     (scroll_y),
        .req_o  (mem_req),
        .addr_o (mem_addr)
    );

    bsa_palette #(
        .CW(CW), .IW(IW), .BKW(BKW)
    ) palette_i (
        .clk   (clk),
        .we    (pal_we),
        .waddr (pal_waddr),
        .wdata (pal_wdata),
        .raddr (pal_raddr),
        .rdata (pal_rdata)
    );

    bsa_pix_out #(
        .CW(CW), .DW(DW), .IW(IW), .BKW(BKW)
    ) pix_out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_vld  (fetch_vld),
        .fetch_data (fetch_data),
        .fmt        (fmt),
        .bank       (bank_sel),
        .pal_raddr  (pal_raddr),
        .pal_rdata  (pal_rdata),
        .colour_o   (colour),
        .vld_o      (colour_vld)
    );

endmodule

// File: tb/bmp_scan_fetch_tb.sv
module bmp_scan_fetch_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  pix_x = '0;
    logic [8:0]  pix_y = '0;
    logic        pix_de = 1'b0;
    logic        mode_half = 1'b0;
    logic [1:0]  width_sel = '0;
    logic        fmt_index8 = 1'b0;
    logic [1:0]  bank_sel = '0;
    logic [20:0] fb_base = '0;
    logic [11:0] scroll_x = '0;
    logic [11:0] scroll_y = '0;
    logic        pal_we = 1'b0;
    logic [9:0]  pal_waddr = '0;
    logic [11:0] pal_wdata = '0;
    logic        fetch_vld = 1'b0;
    logic [15:0] fetch_data = '0;
    logic        mem_req;
    logic [20:0] mem_addr;
    logic [11:0] colour;
    logic        colour_vld;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bmp_scan_fetch dut_i (
        .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y), .pix_de(pix_de),
        .mode_half(mode_half), .width_sel(width_sel), .fmt_index8(fmt_index8),
        .bank_sel(bank_sel), .fb_base(fb_base), .scroll_x(scroll_x),
        .scroll_y(scroll_y), .pal_we(pal_we), .pal_waddr(pal_waddr),
        .pal_wdata(pal_wdata), .fetch_vld(fetch_vld), .fetch_data(fetch_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .colour(colour),
        .colour_vld(colour_vld)
    );

    typedef struct packed {
        logic        half;
        logic [1:0]  wsel;
        logic        idx8;
        logic [20:0] base;
        logic [11:0] sx;
        logic [11:0] sy;
        logic [9:0]  x;
        logic [8:0]  y;
        logic [20:0] exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 1'b1, 21'd0,        12'd0,    12'd0,    10'd5,  9'd2, 21'd1029},    // R2 R3 plain
        '{1'b0, 2'd1, 1'b1, 21'd256,      12'd3,    12'd1,    10'd10, 9'd4, 21'd5389},    // R2 R3 1024 wide
        '{1'b0, 2'd0, 1'b1, 21'd0,        12'd500,  12'd0,    10'd20, 9'd0, 21'd8},       // R4 column wrap
        '{1'b0, 2'd0, 1'b0, 21'd0,        12'd0,    12'd0,    10'd7,  9'd3, 21'd3086},    // R2 two bytes
        '{1'b1, 2'd0, 1'b1, 21'd0,        12'd0,    12'd0,    10'd9,  9'd5, 21'd1028},    // R6 halved
        '{1'b0, 2'd3, 1'b1, 21'd0,        12'd0,    12'd510,  10'd0,  9'd3, 21'd4096},    // R5 row wrap 4096
        '{1'b0, 2'd0, 1'b1, 21'h1FFFF0,   12'd0,    12'd0,    10'd32, 9'd0, 21'd16},      // R2 base wraps
        '{1'b0, 2'd2, 1'b0, 21'd0,        12'd2047, 12'd0,    10'd2,  9'd1, 21'd4098},    // R4 wrap 2048 direct
        '{1'b0, 2'd0, 1'b0, 21'd0,        12'd0,    12'd2047, 10'd0,  9'd2, 21'd1024}     // R5 row wrap direct
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic pal_write(input logic [1:0] bk, input logic [7:0] idx, input logic [11:0] val);
        @(negedge clk);
        pal_we    = 1'b1;
        pal_waddr = {bk, idx};
        pal_wdata = val;
        @(negedge clk);
        pal_we    = 1'b0;
    endtask

    task automatic drive_px(input logic [9:0] x, input logic [8:0] y);
        pix_x  = x;
        pix_y  = y;
        pix_de = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [20:0] held;
        // R1 reset state
        pix_de    = 1'b1;
        fetch_vld = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
        chk("R1 mem_addr", 32'(mem_addr), 32'd0);
        chk("R1 colour_vld", 32'(colour_vld), 32'd0);
        chk("R1 colour", 32'(colour), 32'd0);
        pix_de    = 1'b0;
        fetch_vld = 1'b0;
        rst_n     = 1'b1;
        @(negedge clk);
        chk("R1 mem_req after release", 32'(mem_req), 32'd0);

        // R2..R6 address table
        for (int i = 0; i < NV; i++) begin
            mode_half  = VECS[i].half;
            width_sel  = VECS[i].wsel;
            fmt_index8 = VECS[i].idx8;
            fb_base    = VECS[i].base;
            scroll_x   = VECS[i].sx;
            scroll_y   = VECS[i].sy;
            drive_px(VECS[i].x, VECS[i].y);
            chk("R2 mem_req", 32'(mem_req), 32'd1);
            chk($sformatf("R2 R3 R4 R5 R6 addr vec %0d", i), 32'(mem_addr), 32'(VECS[i].exp));
        end

        // R7 blanking holds the address
        held   = mem_addr;
        pix_de = 1'b0;
        pix_x  = 10'd300;
        @(negedge clk);
        chk("R7 mem_req low", 32'(mem_req), 32'd0);
        chk("R7 addr held", 32'(mem_addr), 32'(held));

        // R6 a 2x2 block maps to one address
        mode_half  = 1'b1;
        width_sel  = 2'd0;
        fmt_index8 = 1'b1;
        fb_base    = '0;
        scroll_x   = '0;
        scroll_y   = '0;
        for (int yy = 4; yy < 6; yy++) begin
            for (int xx = 8; xx < 10; xx++) begin
                drive_px(10'(xx), 9'(yy));
                chk("R6 doubled pixel", 32'(mem_addr), 32'd1028);
            end
        end
        drive_px(10'd10, 9'd4);
        chk("R6 next source pixel", 32'(mem_addr), 32'd1029);
        pix_de = 1'b0;

        // R10 table writes to two banks at the same index
        pal_write(2'd0, 8'h12, 12'hABC);
        pal_write(2'd2, 8'h12, 12'h123);
        pal_write(2'd3, 8'hFF, 12'h7E1);

        // R9 index lookup, upper byte ignored
        @(negedge clk);
        fmt_index8 = 1'b1;
        bank_sel   = 2'd0;
        fetch_vld  = 1'b1;
        fetch_data = 16'hFF12;
        @(negedge clk);
        chk("R9 colour_vld", 32'(colour_vld), 32'd1);
        chk("R9 R10 bank0", 32'(colour), 32'hABC);
        bank_sel   = 2'd2;
        fetch_data = 16'h0012;
        @(negedge clk);
        chk("R9 R10 bank2", 32'(colour), 32'h123);
        bank_sel   = 2'd3;
        fetch_data = 16'h12FF;
        @(negedge clk);
        chk("R9 R10 bank3 top entry", 32'(colour), 32'h7E1);

        // R8 direct colour
        fmt_index8 = 1'b0;
        fetch_data = 16'hF456;
        @(negedge clk);
        chk("R8 colour_vld", 32'(colour_vld), 32'd1);
        chk("R8 direct colour", 32'(colour), 32'h456);

        // R11 idle output
        fetch_vld  = 1'b0;
        fetch_data = 16'h0FFF;
        @(negedge clk);
        chk("R11 colour_vld low", 32'(colour_vld), 32'd0);
        chk("R11 colour zero", 32'(colour), 32'd0);

        done = 1'b1;
        finish_run();
    end

endmodule